// File: doc/BRIEF.md
# Sliding-Window Median Stream Operator

This block turns a stream of 32-bit unsigned tuples into a stream of medians. For every tuple it accepts, it returns the median of that tuple and the seven tuples before it. The producer pushes tuples into a small input queue. A control state machine takes one tuple at a time from that queue and shifts it into an eight-entry window register, and the oldest entry falls off. After a fixed settling delay the state machine stores the median of the window in an output queue, where the consumer reads it. The two queues decouple producer and consumer from the compute path, so no handshake is needed beyond watching the queue counts.

The eight window entries feed a comparator network that is cut down to yield only the fourth and fifth smallest values. These two values are added in 33 bits, and the top 32 bits of the sum form the result, which is the floored mean. After reset every window slot holds zero, and results are produced from the first tuple onward.

The control machine has three states. ST_IDLE waits for work. On the transition *start*, taken when the input queue is non-empty and the output queue is not full, it pops a tuple, shifts the window and moves to ST_SETTLE. ST_SETTLE counts settling cycles. On the transition *settled*, taken after SETTLE_CYC−1 cycles, it moves to ST_PUSH. ST_PUSH writes the median into the output queue and takes the transition *done* back to ST_IDLE. SETTLE_CYC defaults to 2 and may be raised to 3. It must be at least 2.

Top module: `streaming_median`

## Requirements
- R1: After reset, in_free equals FIFO_DEPTH, out_avail is 0 and all eight window slots hold zero.
- R2: Every tuple accepted into the input queue produces exactly one result. Results leave in the order their tuples arrived.
- R3: Each result is floor((a+b)/2), where a and b are the 4th and 5th smallest of the last eight accepted tuples, compared unsigned, and the sum a+b is formed without loss of its carry bit.
- R4: Window slots not yet filled since reset count as zero. The first tuple after reset therefore yields 0, and four equal tuples v yield v/2 (floored).
- R5: With the core idle and both queues empty, a tuple written at clock edge A is visible in the output queue (out_avail = 1) after edge A+SETTLE_CYC+1 and not before.
- R6: A write while in_free is 0 is ignored. in_free stays 0, and that tuple never produces a result.
- R7: A read while out_avail is 0 is ignored. out_avail stays 0, and later results are unaffected.
- R8: While the output queue holds FIFO_DEPTH results, the core takes no tuple from the input queue. No result is lost, and processing resumes once the consumer reads.
- R9: out_data always shows the oldest unread result. A read (out_rd while out_avail > 0) removes that result.
- R10: in_free is FIFO_DEPTH minus the number of queued input tuples, and out_avail is the number of queued results. Each lies in 0..FIFO_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_wr | input | 1 | Write strobe for the input queue |
| in_data | input | 32 | Tuple value, unsigned |
| in_free | output | $clog2(FIFO_DEPTH+1) | Free slots in the input queue |
| out_rd | input | 1 | Read strobe for the output queue |
| out_data | output | 32 | Oldest unread median |
| out_avail | output | $clog2(FIFO_DEPTH+1) | Results waiting in the output queue |

## Verification
A tuple written at edge A is popped at edge A+1, shifted into the window at that same edge, and its median is queued at edge A+1+SETTLE_CYC. That makes the result visible SETTLE_CYC+1 edges after the write, which is 3 at the default. The bench drives inputs on falling edges and samples on falling edges. It checks out_avail one edge before and at the due edge. After that, each table vector waits four edges before reading. The backpressure and overflow tests wait far longer than the worst-case drain time, and then compare the queue counts and the in-order result stream against a reference window model.

// File: rtl/median_pkg.sv
package median_pkg;
    localparam int DATA_W = 32;
    localparam int WIN    = 8;

    typedef logic [DATA_W-1:0] word_t;
    typedef word_t [WIN-1:0]   win_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_PUSH
    } core_st_t;
endpackage

// File: rtl/mwin_fifo.sv
module mwin_fifo
    import median_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  word_t         wr_data,
    input  logic          rd_en,
    output word_t         rd_data,
    output logic [CW-1:0] count
);
    word_t          mem [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic           do_wr, do_rd;

    assign do_wr   = wr_en && (int'(count) != DEPTH);
    assign do_rd   = rd_en && (count != '0);
    assign rd_data = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/mwin_window.sv
module mwin_window
    import median_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  shift,
    input  word_t din,
    output win_t  win
);
    for (genvar i = 0; i < WIN; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)     win[i] <= '0;
            else if (shift) win[i] <= (i == 0) ? din : win[(i == 0) ? 0 : i - 1];
        end
    end
endmodule

// File: rtl/mwin_median.sv
module mwin_median
    import median_pkg::*;
(
    input  win_t  win,
    output word_t med
);
    // Odd-even merge network for eight lanes, with the two comparators
    // of the last layer that do not touch lanes 3 and 4 removed.
    localparam int NCMP = 17;
    localparam int LO [NCMP] = '{0,2,4,6, 0,1,4,5, 1,5, 0,1,2,3, 2,3, 3};
    localparam int HI [NCMP] = '{1,3,5,7, 2,3,6,7, 2,6, 4,5,6,7, 4,5, 4};

    win_t               lanes;
    word_t              tmp;
    logic [DATA_W:0]    sum;

    always_comb begin
        lanes = win;
        tmp   = '0;
        for (int k = 0; k < NCMP; k++) begin
            if (lanes[LO[k]] > lanes[HI[k]]) begin
                tmp           = lanes[LO[k]];
                lanes[LO[k]]  = lanes[HI[k]];
                lanes[HI[k]]  = tmp;
            end
        end
    end

    assign sum = {1'b0, lanes[WIN/2-1]} + {1'b0, lanes[WIN/2]};
    assign med = sum[DATA_W:1];
endmodule

// File: rtl/streaming_median.sv
module streaming_median
    import median_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int SETTLE_CYC = 2,
    localparam int CW = $clog2(FIFO_DEPTH + 1),
    localparam int SW = $clog2(SETTLE_CYC) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_wr,
    input  logic [31:0]   in_data,
    output logic [CW-1:0] in_free,
    input  logic          out_rd,
    output logic [31:0]   out_data,
    output logic [CW-1:0] out_avail
);
    core_st_t       state, state_nxt;
    logic [SW-1:0]  settle_cnt;
    logic [CW-1:0]  in_cnt;
    logic           in_pop, out_push;
    word_t          head, med;
    win_t           win;

    mwin_fifo #(.DEPTH(FIFO_DEPTH)) in_q_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(in_wr), .wr_data(in_data),
        .rd_en(in_pop), .rd_data(head),
        .count(in_cnt)
    );

    mwin_window win_i (
        .clk(clk), .rst_n(rst_n),
        .shift(in_pop), .din(head), .win(win)
    );

    mwin_median med_i (
        .win(win), .med(med)
    );

    mwin_fifo #(.DEPTH(FIFO_DEPTH)) out_q_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(out_push), .wr_data(med),
        .rd_en(out_rd), .rd_data(out_data),
        .count(out_avail)
    );

    assign in_free = CW'(FIFO_DEPTH) - in_cnt;

    // state register and settle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            settle_cnt <= '0;
        end else begin
            state      <= state_nxt;
            settle_cnt <= (state == ST_SETTLE) ? settle_cnt + 1'b1 : '0;
        end
    end

    // next state and outputs
    always_comb begin
        state_nxt = state;
        in_pop    = 1'b0;
        out_push  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (in_cnt != '0 && int'(out_avail) != FIFO_DEPTH) begin
                    in_pop    = 1'b1;
                    state_nxt = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (int'(settle_cnt) == SETTLE_CYC - 2) state_nxt = ST_PUSH;
            end
            ST_PUSH: begin
                out_push  = 1'b1;
                state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/streaming_median_chk.sv
module streaming_median_chk #(
    parameter int DEPTH  = 4,
    parameter int SETTLE = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_wr,
    input logic          out_rd,
    input logic [CW-1:0] in_free,
    input logic [CW-1:0] out_avail,
    input logic          in_pop,
    input logic          out_push
);
    // R10
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(in_free) <= DEPTH && int'(out_avail) <= DEPTH);

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(out_avail) == DEPTH |-> !in_pop);

    // R2
    single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_pop |=> !in_pop);

    // R5
    settle_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_push |-> $past(in_pop, SETTLE));

    // R7
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_avail == '0 && out_rd && !out_push) |=> out_avail == '0);

    // R6
    full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_free == '0 && in_wr && !in_pop) |=> in_free == '0);
endmodule

bind streaming_median streaming_median_chk #(.DEPTH(FIFO_DEPTH), .SETTLE(SETTLE_CYC)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_wr(in_wr), .out_rd(out_rd),
    .in_free(in_free), .out_avail(out_avail),
    .in_pop(in_pop), .out_push(out_push)
);

// File: tb/streaming_median_tb_top.sv
`timescale 1ns/1ps
module streaming_median_tb_top;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int NV    = 14;

    // R3 R4 table: tuple in, expected median out, starting from a reset window
    localparam logic [31:0] VEC_IN [NV] = '{
        32'd10, 32'd20, 32'd30, 32'd40, 32'd50, 32'd60, 32'd70, 32'd80, 32'd5,
        32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'hFFFF_FFFD, 32'hFFFF_FFFC, 32'hFFFF_FFFB};
    localparam logic [31:0] VEC_EXP [NV] = '{
        32'd0, 32'd0, 32'd0, 32'd5, 32'd15, 32'd25, 32'd35, 32'd45, 32'd45,
        32'd55, 32'd65, 32'd75, 32'h8000_0026, 32'hFFFF_FFFB};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_wr = 1'b0;
    logic [31:0]   in_data = '0;
    logic          out_rd = 1'b0;
    logic [CW-1:0] in_free, out_avail;
    logic [31:0]   out_data;

    int total = 0;
    int bad   = 0;

    logic [31:0] bw [8];
    logic [31:0] expq [$];

    always #2.5 clk = ~clk;

    streaming_median #(.FIFO_DEPTH(DEPTH), .SETTLE_CYC(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_wr(in_wr), .in_data(in_data),
        .in_free(in_free), .out_rd(out_rd), .out_data(out_data),
        .out_avail(out_avail)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_med();
        logic [31:0] s [8];
        logic [31:0] t;
        logic [32:0] sum;
        for (int i = 0; i < 8; i++) s[i] = bw[i];
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 7 - i; j++)
                if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
        sum = {1'b0, s[3]} + {1'b0, s[4]};
        return sum[32:1];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_wr = 1'b0; out_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) bw[i] = '0;
        expq.delete();
    endtask

    // drive one write; accepted says whether the model takes it
    task automatic put(input logic [31:0] v, input bit accepted);
        in_wr = 1'b1; in_data = v;
        @(negedge clk);
        in_wr = 1'b0;
        if (accepted) begin
            for (int i = 7; i > 0; i--) bw[i] = bw[i-1];
            bw[0] = v;
            expq.push_back(ref_med());
        end
    endtask

    task automatic take(input string req);
        logic [31:0] e;
        e = (expq.size() != 0) ? expq.pop_front() : 32'hDEAD_BEEF;
        check(out_avail != '0, req, 32'(out_avail), 32'd1);
        check(out_data == e, req, out_data, e);
        out_rd = 1'b1;
        @(negedge clk);
        out_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check(int'(in_free) == DEPTH, "R1", 32'(in_free), DEPTH);
        check(out_avail == '0, "R1", 32'(out_avail), 0);

        // R5 latency of the first result
        @(negedge clk);
        put(VEC_IN[0], 1'b1);
        @(negedge clk);
        check(int'(in_free) == DEPTH, "R10", 32'(in_free), DEPTH);
        @(negedge clk);
        check(out_avail == '0, "R5", 32'(out_avail), 0);
        @(negedge clk);
        check(out_avail == 1, "R5", 32'(out_avail), 1);
        check(out_data == VEC_EXP[0], "R4", out_data, VEC_EXP[0]);
        take("R9");
        check(out_avail == '0, "R9", 32'(out_avail), 0);

        // table walk: R3 incl. carry of the 33-bit sum
        for (int k = 1; k < NV; k++) begin
            put(VEC_IN[k], 1'b1);
            repeat (4) @(negedge clk);
            check(out_avail == 1, "R2", 32'(out_avail), 1);
            check(out_data == VEC_EXP[k], "R3", out_data, VEC_EXP[k]);
            void'(expq.pop_front());
            out_rd = 1'b1; @(negedge clk); out_rd = 1'b0;
        end

        // R4 four equal tuples after reset
        do_reset();
        for (int k = 0; k < 4; k++) begin
            put(32'd101, 1'b1);
            repeat (4) @(negedge clk);
            take("R4");
        end

        // R7 read on empty queue
        out_rd = 1'b1; @(negedge clk); out_rd = 1'b0;
        @(negedge clk);
        check(out_avail == '0, "R7", 32'(out_avail), 0);
        put(32'd7, 1'b1);
        repeat (4) @(negedge clk);
        take("R7");

        // R8 backpressure: six writes back to back, no reads
        for (int k = 0; k < 6; k++) put(32'(1000 + 37 * k), 1'b1);
        repeat (40) @(negedge clk);
        check(int'(out_avail) == DEPTH, "R8", 32'(out_avail), DEPTH);
        check(in_free == 2, "R8", 32'(in_free), 2);
        // R6 overflow: two fit, third is dropped
        put(32'd500, 1'b1);
        put(32'd600, 1'b1);
        put(32'hFFFF_0000, 1'b0);
        @(negedge clk);
        check(in_free == '0, "R6", 32'(in_free), 0);
        // drain all eight in order
        for (int k = 0; k < 8; k++) begin
            take("R8");
            repeat (4) @(negedge clk);
        end
        repeat (20) @(negedge clk);
        check(out_avail == '0, "R6", 32'(out_avail), 0);
        check(int'(in_free) == DEPTH, "R10", 32'(in_free), DEPTH);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule